// File: doc/BRIEF.md
# Multiprocessor Interrupt Distributor

This block is the central interrupt arbiter for a cluster of four processors. It gathers three kinds of sources: 32 level-sensitive shared hardware lines, a private timer line and a private watchdog line for each processor, and software-raised inter-processor interrupts. For every interrupt number it keeps a separate state on each processor: idle, waiting, or in service. Enable masks and 4-bit priorities decide which waiting interrupt is offered. Shared lines are steered by a per-line processor mask, so one line can reach one processor, a group of processors or all of them.

Each processor has a request output and the number of the interrupt being offered. A one-cycle take pulse moves the offered interrupt into service. A one-cycle finish pulse, which carries an interrupt number, returns that interrupt to idle on that processor only. Configuration goes through a single write port. Each write is tagged with the number of the processor that issues it, because private enables and priorities are kept in one bank per processor.

Interrupt number bands: 0 to 15 are software interrupts, 29 is the private timer, 30 is the private watchdog, and 32 to 63 are shared lines 0 to 31. Configuration addresses: 0 holds the global enable in bit 0. 1 raises a software interrupt: number in bits [3:0], processor list in bits [11:8], mode in bits [17:16] (0 = list, 1 = every processor except the writer, 2 = the writer only, 3 = nothing). 2 holds the private enable word for numbers 0 to 31 of the writer. 3 holds the enable word for shared lines. 4 sets a priority: number in bits [7:0], value in bits [11:8], banked by the writer for numbers below 32. 5 sets a route: line in bits [7:0], processor mask in bits [11:8].

Top module: `mpirq_dist`

## Requirements
- R1: After reset every request output is low and every offered number reads 1023.
- R2: A high shared line k becomes waiting, and is offered as number 32+k, on exactly the processors set in its route mask.
- R3: Among waiting, enabled interrupts, the lowest priority value is offered, and the lowest number wins a tie. When nothing qualifies, the request is low and the number is 1023.
- R4: A take pulse while a request is high moves the offered interrupt to in-service. The request then drops unless another interrupt outranks it.
- R5: While an interrupt is in service, the request rises again only for a waiting interrupt whose priority value is strictly lower. An equal value is held back.
- R6: A finish pulse returns the named in-service interrupt to idle. If its level line is still high, it becomes waiting again and is offered again.
- R7: Finishing an interrupt on one processor leaves its state on the other processors unchanged.
- R8: A software request marks its interrupt waiting on the processors chosen by its mode: list, all but the writer, or the writer only.
- R9: A software interrupt is ranked with the priority in the receiving processor's bank, not the sender's.
- R10: A processor's timer line raises number 29 and its watchdog line raises number 30, on that processor only.
- R11: A cleared enable bit, or a cleared global enable, stops a waiting interrupt from being offered.
- R12: A waiting level interrupt whose line falls before it is taken returns to idle and is no longer offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_cpu | input | 2 | Processor issuing the write |
| cfg_addr | input | 3 | Configuration address |
| cfg_wdata | input | 32 | Configuration write data |
| hw_irq | input | 32 | Shared level interrupt lines |
| tmr_irq | input | 4 | Private timer line per processor |
| wdg_irq | input | 4 | Private watchdog line per processor |
| cpu_ack | input | 4 | Take pulse per processor |
| cpu_eoi | input | 4 | Finish pulse per processor |
| cpu_eoi_id | input | 24 | Number being finished, 6 bits per processor |
| cpu_irq | output | 4 | Request per processor (registered) |
| cpu_irq_id | output | 40 | Offered number, 10 bits per processor (registered) |

## Verification
The hardest situation to reach is two processors holding the same shared interrupt in different states, together with a priority comparison against the priority of the interrupt in service. Both require a chain of take and finish pulses in a fixed order. The stimulus routes one line to two processors and takes it on both. It finishes the interrupt on one processor only, then raises a second line of equal priority on the other processor. That processor's request staying low shows that its copy is still in service. Preemption is reached the same way: an interrupt is taken, and then a line of equal priority and a line of strictly lower priority value are raised one after the other.

// File: rtl/mpirq_pkg.sv
package mpirq_pkg;
  localparam int ID_W = 10;
  localparam logic [ID_W-1:0] SPURIOUS = 10'd1023;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PEND = 2'd1,
    ST_ACT  = 2'd2
  } irq_st_e;

  localparam logic [2:0] ADR_CTRL  = 3'd0;
  localparam logic [2:0] ADR_SOFT  = 3'd1;
  localparam logic [2:0] ADR_PEN   = 3'd2;
  localparam logic [2:0] ADR_SEN   = 3'd3;
  localparam logic [2:0] ADR_PRIO  = 3'd4;
  localparam logic [2:0] ADR_ROUTE = 3'd5;

  localparam logic [1:0] SOFT_LIST = 2'd0;
  localparam logic [1:0] SOFT_OTHR = 2'd1;
  localparam logic [1:0] SOFT_SELF = 2'd2;
endpackage

// File: rtl/mpirq_cfg.sv
module mpirq_cfg
  import mpirq_pkg::*;
#(
  parameter int NCPU = 4,
  parameter int NHW  = 32,
  parameter int PW   = 4,
  parameter int NSGI = 16,
  parameter int CW   = $clog2(NCPU),
  parameter int HIW  = $clog2(NHW)
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               we,
  input  logic [CW-1:0]                      wcpu,
  input  logic [2:0]                         addr,
  input  logic [31:0]                        wdata,
  output logic                               gen,
  output logic [NCPU-1:0][31:0]              priv_en,
  output logic [NHW-1:0]                     shr_en,
  output logic [NCPU-1:0][31:0][PW-1:0]      priv_pri,
  output logic [NHW-1:0][PW-1:0]             shr_pri,
  output logic [NHW-1:0][NCPU-1:0]           route,
  output logic [NCPU-1:0][NSGI-1:0]          sgi_set
);
  logic [NCPU-1:0] self_mask, soft_tgt;
  logic [7:0]      pid, sidx;
  logic [3:0]      sgi_num;

  assign self_mask = NCPU'(1) << wcpu;
  assign pid       = wdata[7:0];
  assign sidx      = pid - 8'd32;
  assign sgi_num   = wdata[3:0];

  always_comb begin
    case (wdata[17:16])
      SOFT_LIST: soft_tgt = wdata[8 +: NCPU];
      SOFT_OTHR: soft_tgt = ~self_mask;
      SOFT_SELF: soft_tgt = self_mask;
      default:   soft_tgt = '0;
    endcase
  end

  // software requests act in the write cycle itself
  always_comb begin
    sgi_set = '0;
    if (we && addr == ADR_SOFT)
      for (int c = 0; c < NCPU; c++)
        if (soft_tgt[c]) sgi_set[c][sgi_num] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gen      <= 1'b0;
      priv_en  <= '0;
      shr_en   <= '0;
      priv_pri <= '0;
      shr_pri  <= '0;
      route    <= '0;
    end else if (we) begin
      case (addr)
        ADR_CTRL: gen <= wdata[0];
        ADR_PEN:  priv_en[wcpu] <= wdata;
        ADR_SEN:  shr_en <= wdata[NHW-1:0];
        ADR_PRIO: begin
          if (pid < 8'd32) priv_pri[wcpu][pid[4:0]] <= wdata[8 +: PW];
          else if (sidx < 8'(NHW)) shr_pri[sidx[HIW-1:0]] <= wdata[8 +: PW];
        end
        ADR_ROUTE: if (pid < 8'(NHW)) route[pid[HIW-1:0]] <= wdata[8 +: NCPU];
        default: ;
      endcase
    end
  end

  AST_ROUTE_KEPT: assert property (@(posedge clk) disable iff (rst) !(we && addr == ADR_ROUTE) |=> $stable(route)) else $error("route changed without write"); // R2
endmodule

// File: rtl/mpirq_cpu.sv
module mpirq_cpu
  import mpirq_pkg::*;
#(
  parameter int NID  = 64,
  parameter int PW   = 4,
  parameter int NSGI = 16,
  parameter int EW   = $clog2(NID)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     gen,
  input  logic [NID-1:0]           en,
  input  logic [NID-1:0][PW-1:0]   pri,
  input  logic [NID-1:0]           lvl,
  input  logic [NSGI-1:0]          sgi,
  input  logic                     ack,
  input  logic                     eoi,
  input  logic [EW-1:0]            eoi_id,
  output logic                     irq,
  output logic [ID_W-1:0]          irq_id
);
  localparam logic [NID-1:0] LVL_MASK = {{(NID-NSGI){1'b1}}, {NSGI{1'b0}}};

  irq_st_e        st [NID];
  logic [NID-1:0] raise, drop;
  logic [PW:0]    best_pri, run_pri;
  logic [EW-1:0]  best_id;
  logic           fire;

  assign raise = lvl | {{(NID-NSGI){1'b0}}, sgi};
  assign drop  = ~lvl & LVL_MASK;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NID; i++) st[i] <= ST_IDLE;
    end else begin
      for (int i = 0; i < NID; i++) begin
        case (st[i])
          ST_IDLE: if (raise[i]) st[i] <= ST_PEND;
          ST_PEND: begin
            if (ack && irq && irq_id == ID_W'(i)) st[i] <= ST_ACT;
            else if (drop[i]) st[i] <= ST_IDLE;
          end
          ST_ACT:  if (eoi && eoi_id == EW'(i)) st[i] <= ST_IDLE;
          default: st[i] <= ST_IDLE;
        endcase
      end
    end
  end

  // strict compare in ascending order: lowest number wins ties
  always_comb begin
    best_pri = {1'b1, {PW{1'b0}}};
    run_pri  = {1'b1, {PW{1'b0}}};
    best_id  = '0;
    for (int i = 0; i < NID; i++) begin
      if (st[i] == ST_ACT && {1'b0, pri[i]} < run_pri) run_pri = {1'b0, pri[i]};
      if (st[i] == ST_PEND && en[i] && {1'b0, pri[i]} < best_pri) begin
        best_pri = {1'b0, pri[i]};
        best_id  = EW'(i);
      end
    end
    fire = gen && !best_pri[PW] && (best_pri < run_pri);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq    <= 1'b0;
      irq_id <= SPURIOUS;
    end else begin
      irq    <= fire;
      irq_id <= fire ? ID_W'(best_id) : SPURIOUS;
    end
  end

  AST_ACK_ACTIVATES: assert property (@(posedge clk) disable iff (rst) (ack && irq && st[irq_id[EW-1:0]] == ST_PEND) |=> st[$past(irq_id[EW-1:0])] == ST_ACT) else $error("take lost"); // R4
  AST_EOI_RETIRES: assert property (@(posedge clk) disable iff (rst) (eoi && st[eoi_id] == ST_ACT) |=> st[$past(eoi_id)] != ST_ACT) else $error("finish lost"); // R6
  AST_GATED_OFF: assert property (@(posedge clk) disable iff (rst) !gen |=> !irq) else $error("request while disabled"); // R11

  for (genvar g = 0; g < NSGI; g++) begin : g_sgi_chk
    AST_SGI_CAPTURE: assert property (@(posedge clk) disable iff (rst) (sgi[g] && st[g] == ST_IDLE) |=> st[g] == ST_PEND) else $error("software request lost"); // R8
  end
endmodule

// File: rtl/mpirq_dist.sv
module mpirq_dist
  import mpirq_pkg::*;
#(
  parameter int NCPU = 4,
  parameter int NHW  = 32,
  parameter int PW   = 4,
  parameter int NSGI = 16,
  parameter int TMR_ID = 29,
  parameter int WDG_ID = 30,
  parameter int NID  = 32 + NHW,
  parameter int EW   = $clog2(NID),
  parameter int CW   = $clog2(NCPU)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic [CW-1:0]        cfg_cpu,
  input  logic [2:0]           cfg_addr,
  input  logic [31:0]          cfg_wdata,
  input  logic [NHW-1:0]       hw_irq,
  input  logic [NCPU-1:0]      tmr_irq,
  input  logic [NCPU-1:0]      wdg_irq,
  input  logic [NCPU-1:0]      cpu_ack,
  input  logic [NCPU-1:0]      cpu_eoi,
  input  logic [NCPU*EW-1:0]   cpu_eoi_id,
  output logic [NCPU-1:0]      cpu_irq,
  output logic [NCPU*ID_W-1:0] cpu_irq_id
);
  logic                          gen;
  logic [NCPU-1:0][31:0]         priv_en;
  logic [NHW-1:0]                shr_en;
  logic [NCPU-1:0][31:0][PW-1:0] priv_pri;
  logic [NHW-1:0][PW-1:0]        shr_pri;
  logic [NHW-1:0][NCPU-1:0]      route;
  logic [NCPU-1:0][NSGI-1:0]     sgi_set;

  mpirq_cfg #(.NCPU(NCPU), .NHW(NHW), .PW(PW), .NSGI(NSGI)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .wcpu(cfg_cpu), .addr(cfg_addr),
    .wdata(cfg_wdata), .gen(gen), .priv_en(priv_en), .shr_en(shr_en),
    .priv_pri(priv_pri), .shr_pri(shr_pri), .route(route), .sgi_set(sgi_set)
  );

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    logic [NID-1:0]         lvl;
    logic [NID-1:0][PW-1:0] pri;
    logic [NID-1:0]         en;

    always_comb begin
      lvl = '0;
      lvl[TMR_ID] = tmr_irq[c];
      lvl[WDG_ID] = wdg_irq[c];
      for (int k = 0; k < NHW; k++) lvl[32+k] = hw_irq[k] & route[k][c];
    end
    assign pri = {shr_pri, priv_pri[c]};
    assign en  = {shr_en, priv_en[c]};

    mpirq_cpu #(.NID(NID), .PW(PW), .NSGI(NSGI)) u_slice (
      .clk(clk), .rst(rst), .gen(gen), .en(en), .pri(pri), .lvl(lvl),
      .sgi(sgi_set[c]), .ack(cpu_ack[c]), .eoi(cpu_eoi[c]),
      .eoi_id(cpu_eoi_id[c*EW +: EW]), .irq(cpu_irq[c]),
      .irq_id(cpu_irq_id[c*ID_W +: ID_W])
    );
  end
endmodule

// File: tb/mpirq_dist_test.sv
`timescale 1ns/1ps
module mpirq_dist_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_cpu = '0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] hw_irq = '0;
  logic [3:0]  tmr_irq = '0, wdg_irq = '0, cpu_ack = '0, cpu_eoi = '0;
  logic [23:0] cpu_eoi_id = '0;
  logic [3:0]  cpu_irq;
  logic [39:0] cpu_irq_id;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mpirq_dist uut (.*);

  // {hw line pattern, expected number on processor 0}
  localparam logic [41:0] VEC [8] = '{
    {32'h0000_0008, 10'd35}, {32'h0000_0088, 10'd35},
    {32'h0000_0082, 10'd39}, {32'h0000_1008, 10'd44},
    {32'h4000_1000, 10'd62}, {32'h0000_0007, 10'd32},
    {32'h8200_0000, 10'd57}, {32'h0000_0000, 10'd1023}};

  task automatic settle(input int n); repeat (n) @(negedge clk); endtask

  task automatic wr(input int c, input logic [2:0] a, input logic [31:0] d);
    cfg_we = 1; cfg_cpu = 2'(c); cfg_addr = a; cfg_wdata = d;
    @(posedge clk); @(negedge clk); cfg_we = 0;
  endtask

  task automatic chk(input string rq, input int c, input bit eirq, input int eid);
    logic [9:0] id;
    id = cpu_irq_id[c*10 +: 10];
    checks++;
    if (cpu_irq[c] !== eirq || id !== 10'(eid)) begin
      errors++;
      $display("FAIL %s cpu%0d: irq=%0b id=%0d expected irq=%0b id=%0d", rq, c, cpu_irq[c], id, eirq, eid);
    end
  endtask

  task automatic take(input int c);
    cpu_ack[c] = 1; @(posedge clk); @(negedge clk); cpu_ack[c] = 0; settle(3);
  endtask

  task automatic fin(input int c, input int id);
    cpu_eoi[c] = 1; cpu_eoi_id[c*6 +: 6] = 6'(id);
    @(posedge clk); @(negedge clk); cpu_eoi[c] = 0; settle(3);
  endtask

  task automatic service(input string rq, input int c, input int id);
    chk(rq, c, 1, id); take(c); fin(c, id);
  endtask

  initial begin
    settle(3); rst = 0; settle(1);
    for (int c = 0; c < 4; c++) chk("R1", c, 0, 1023);
    wr(0, 3'd0, 32'h1); wr(0, 3'd3, 32'hFFFF_FFFF);
    for (int k = 0; k < 32; k++) begin
      wr(0, 3'd5, 32'h100 | k);
      wr(0, 3'd4, 32'h800 | (32 + k));
    end
    wr(0, 3'd4, 32'h400 | 35); wr(0, 3'd4, 32'h400 | 39); wr(0, 3'd4, 32'h200 | 44);
    wr(0, 3'd4, 32'h600 | 57); wr(0, 3'd4, 32'h000 | 62); wr(0, 3'd4, 32'h200 | 45);
    // R2 / R3 table walk
    foreach (VEC[v]) begin
      hw_irq = VEC[v][41:10]; settle(3);
      chk("R3", 0, VEC[v][9:0] != 10'd1023, VEC[v][9:0]);
      chk("R2", 1, 0, 1023);
    end
    // R11 masking
    hw_irq = 32'h8; settle(3);
    wr(0, 3'd0, 32'h0); settle(3); chk("R11", 0, 0, 1023);
    wr(0, 3'd0, 32'h1); settle(3); chk("R11", 0, 1, 35);
    wr(0, 3'd3, 32'hFFFF_FFF7); settle(3); chk("R11", 0, 0, 1023);
    wr(0, 3'd3, 32'hFFFF_FFFF); hw_irq = 0; settle(3);
    // R4 R5 R6 R12
    hw_irq = 32'h1000; settle(3); chk("R3", 0, 1, 44);
    take(0); chk("R4", 0, 0, 1023);
    hw_irq[13] = 1; settle(3); chk("R5", 0, 0, 1023);
    hw_irq[30] = 1; settle(3); chk("R5", 0, 1, 62);
    take(0); chk("R4", 0, 0, 1023);
    fin(0, 62); chk("R6", 0, 1, 62);
    hw_irq[30] = 0; settle(3); chk("R12", 0, 0, 1023);
    fin(0, 44); chk("R6", 0, 1, 44);
    hw_irq = 0; settle(3); chk("R12", 0, 0, 1023);
    // R7 per-processor state
    wr(0, 3'd5, 32'h300 | 4); wr(0, 3'd5, 32'h200 | 6);
    hw_irq[4] = 1; settle(3); chk("R2", 0, 1, 36); chk("R2", 1, 1, 36);
    take(0); take(1); hw_irq[4] = 0;
    fin(0, 36); chk("R7", 0, 0, 1023);
    hw_irq[6] = 1; settle(3); chk("R7", 1, 0, 1023);
    fin(1, 36); chk("R7", 1, 1, 38);
    hw_irq[6] = 0; settle(3); chk("R12", 1, 0, 1023);
    // private enables and banked priorities
    for (int c = 0; c < 4; c++) begin
      wr(c, 3'd2, 32'h6000_00A0);
      wr(c, 3'd4, 32'h500 | 7); wr(c, 3'd4, 32'h400 | 29); wr(c, 3'd4, 32'h400 | 30);
    end
    wr(0, 3'd4, 32'h300 | 5); wr(1, 3'd4, 32'h900 | 5);
    wr(2, 3'd4, 32'h100 | 5); wr(3, 3'd4, 32'h100 | 5);
    // R8 modes
    wr(2, 3'd1, 32'h2_0000 | 5); settle(3);
    chk("R8", 0, 0, 1023); service("R8", 2, 5);
    wr(2, 3'd1, 32'h1_0000 | 7); settle(3);
    chk("R8", 2, 0, 1023);
    service("R8", 0, 7); service("R8", 1, 7); service("R8", 3, 7);
    // R9 receiver priority
    wr(3, 3'd1, 32'h0300 | 5); wr(3, 3'd1, 32'h0300 | 7); settle(3);
    chk("R9", 3, 0, 1023);
    service("R9", 0, 5); service("R9", 0, 7);
    service("R9", 1, 7); service("R9", 1, 5);
    // R10 private timer and watchdog
    tmr_irq[1] = 1; wdg_irq[1] = 1; settle(3);
    chk("R10", 1, 1, 29); chk("R10", 0, 0, 1023);
    tmr_irq[1] = 0; settle(3); chk("R10", 1, 1, 30);
    wdg_irq[1] = 0; settle(3); chk("R10", 1, 0, 1023);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule